// File: doc/BRIEF.md
# UART Host Register Bank

This block is the host-facing register file of a 16550-style serial port. A simple single-cycle register bus reaches eight 32-bit word slots (byte offsets 0x00 to 0x1C, word aligned). Only the low byte of each word carries data; the upper 24 bits always read zero. A divisor-access bit in the line-control register redirects the two lowest slots from the receive/transmit data path and the interrupt-enable register to the two bytes of the baud divisor.

The bank keeps the configuration state: baud divisor, interrupt enables, line control, FIFO enable, receive trigger level and a scratch byte. It drives these to the serial datapath as plain signals, together with one-cycle FIFO reset pulses and pop/push strobes for the data slot. From level and strobe inputs supplied by the datapath it builds a line-status byte with sticky error flags. It also builds a prioritised interrupt identification byte and a single interrupt line. The serial shifters and FIFO storage sit outside this block.

Top module: `uart_regbank`

## Requirements
- R1: After reset the interrupt-enable, line-control and scratch registers read 0, the divisor output equals the DIV_RST parameter (default 1), the identification word reads 0x01, and irq and both FIFO reset outputs are low.
- R2: Only bits 7:0 of bus_rdata carry data and bits 31:8 always read zero. Word slots 4 and 6 (offsets 0x10 and 0x18) read zero.
- R3: While line-control bit 7 (divisor access) is 1, offset 0x00 reads and writes divisor bits 7:0 and offset 0x04 reads and writes divisor bits 15:8. In that state rx_pop and tx_push stay low.
- R4: While divisor access is 0, a read of offset 0x00 returns rx_data and raises rx_pop in that cycle. A write of offset 0x00 raises tx_push with tx_data equal to write bits 7:0.
- R5: Offset 0x04 (divisor access 0) is the interrupt-enable register. Its bits are: bit 6 unit enable (output unit_en), bit 5 NRZ enable (output nrz_en), bit 4 receive-timeout enable, bit 3 reserved and reading 0, bit 2 line-status-error enable, bit 1 transmit-request enable, and bit 0 receive-data enable.
- R6: Offset 0x0C is line control and reads back as written. Its fields drive outputs: bits 1:0 word_len, bit 2 stop_two, bit 3 parity_en, bit 4 parity_even, bit 5 parity_stick, bit 6 break_ctl. Offset 0x1C is a scratch byte that reads back as written and changes no output.
- R7: A write to offset 0x08 is FIFO control. Bit 0 sets fifo_en and bits 7:6 set rx_trig. The identification word's bits 7:6 read 11 while fifo_en is 1 and 00 otherwise.
- R8: A FIFO-control write with bit 2 set gives tx_fifo_rst high for exactly the cycle after the write. Bit 1 does the same on rx_fifo_rst. The pulses do not repeat.
- R9: Offset 0x14 (line status) reads as follows: bit 7 fifo_err, bit 6 tx_empty AND tx_idle, bit 5 tx_empty, bits 4..1 the sticky break, framing, parity and overrun flags, and bit 0 set when rx_level is nonzero.
- R10: A sticky error flag sets on its strobe and clears after a line-status read. A strobe in the same cycle as that read keeps its flag set.
- R11: With FIFOs disabled the receive-data source is active when rx_level is nonzero. With FIFOs enabled it is active when rx_level reaches the threshold chosen by rx_trig: code 00 is 1 byte, 01 is 8, 10 is 16 and 11 is 32.
- R12: The identification word's bits 3:0 read 0x6 when an enabled error is active, otherwise 0x4 for enabled receive data, or 0xC when an enabled timeout is active. Otherwise they read 0x2 for an enabled transmit request, or 0x1 when nothing is pending. Bit 0 is 0 exactly when some enabled source is active.
- R13: A transmit request sets when tx_empty rises, or when transmit-request enable is written from 0 to 1 while tx_empty is 1. It clears when an identification read reports it, or when the transmit data slot is written.
- R14: irq is high exactly when unit enable is 1 and at least one enabled interrupt source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle |
| rx_data | input | 8 | Head of receive FIFO |
| rx_pop | output | 1 | Receive data slot read |
| tx_push | output | 1 | Transmit data slot write |
| tx_data | output | 8 | Byte for transmit FIFO |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_timeout | input | 1 | Receive timeout condition |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_idle | input | 1 | Transmit shifter idle |
| fifo_err | input | 1 | Error present in receive FIFO |
| set_overrun | input | 1 | Overrun strobe |
| set_parity | input | 1 | Parity error strobe |
| set_framing | input | 1 | Framing error strobe |
| set_brk | input | 1 | Break detected strobe |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Character length code |
| stop_two | output | 1 | Extra stop bit |
| parity_en | output | 1 | Parity enable |
| parity_even | output | 1 | Even parity select |
| parity_stick | output | 1 | Stick parity |
| break_ctl | output | 1 | Force line break |
| unit_en | output | 1 | Unit enable |
| nrz_en | output | 1 | NRZ coding enable |
| fifo_en | output | 1 | FIFOs enabled |
| rx_trig | output | 2 | Receive trigger code |
| tx_fifo_rst | output | 1 | Transmit FIFO reset pulse |
| rx_fifo_rst | output | 1 | Receive FIFO reset pulse |
| irq | output | 1 | Interrupt request |

## Verification
The identification logic gets random mixes of enable masks, FIFO mode, trigger code, fill level and timeout. These separate threshold comparison from the plain nonempty test and show the timeout flag beside receive data. Directed sequences place an error beside receive data to expose priority. They also raise transmit requests by an edge, by an enable write and by clearing reads and data writes, which tells the set paths from the clear paths. The sticky flags see a strobe that lands exactly on the clearing read. The shared slots are tried with divisor access on and off, to catch a wrong steering of reads, writes and pop/push strobes.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
    localparam int REG_W = 8;
    localparam int DIV_W = 2 * REG_W;
    localparam int IER_W = 7;

    typedef enum logic [2:0] {
        OFS_DATA = 3'd0,
        OFS_IER  = 3'd1,
        OFS_IIR  = 3'd2,
        OFS_LCR  = 3'd3,
        OFS_GAP4 = 3'd4,
        OFS_LSR  = 3'd5,
        OFS_GAP6 = 3'd6,
        OFS_SCR  = 3'd7
    } ofs_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'b00,
        SRC_TXREQ  = 2'b01,
        SRC_RXDATA = 2'b10,
        SRC_RXERR  = 2'b11
    } src_e;

    // interrupt-enable bit positions
    localparam int IE_RDA  = 0;
    localparam int IE_TX   = 1;
    localparam int IE_LS   = 2;
    localparam int IE_RSV  = 3;
    localparam int IE_RTO  = 4;
    localparam int IE_NRZ  = 5;
    localparam int IE_UNIT = 6;

    // line-control bit positions
    localparam int LC_STOP  = 2;
    localparam int LC_PEN   = 3;
    localparam int LC_EVEN  = 4;
    localparam int LC_STICK = 5;
    localparam int LC_BRK   = 6;
    localparam int LC_DLAB  = 7;

    // FIFO-control bit positions
    localparam int FC_EN    = 0;
    localparam int FC_RXRST = 1;
    localparam int FC_TXRST = 2;
    localparam int FC_TRIG  = 6;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [IER_W-1:0] ier;
        logic [REG_W-1:0] lcr;
        logic [REG_W-1:0] scr;
        logic             fifo_en;
        logic [1:0]       trig;
        logic             rx_rst;
        logic             tx_rst;
        logic             thr_req;
        logic             tx_empty_prev;
    } regs_t;
endpackage

// File: rtl/uart_rb_lsr.sv
module uart_rb_lsr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set_oe,
    input  logic       set_pe,
    input  logic       set_fe,
    input  logic       set_bi,
    output logic [3:0] sticky
);
    // order {break, framing, parity, overrun}
    logic [3:0] sticky_d, sticky_q;

    always_comb begin
        sticky_d = clr ? 4'b0000 : sticky_q;
        sticky_d = sticky_d | {set_bi, set_fe, set_pe, set_oe};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= 4'b0000;
        else        sticky_q <= sticky_d;
    end

    assign sticky = sticky_q;
endmodule

// File: rtl/uart_rb_intid.sv
module uart_rb_intid
    import uart_rb_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic [IER_W-1:0] ier,
    input  logic             fifo_en,
    input  logic [1:0]       trig,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_timeout,
    input  logic             err_any,
    input  logic             thr_req,
    output logic [3:0]       id_low,
    output src_e             src,
    output logic             any_src
);
    localparam int CMP_W = LVL_W + 1;

    logic [CMP_W-1:0] thresh;
    logic rda_hit, s_err, s_rda, s_to, s_tx;

    always_comb begin
        if (trig == 2'b00) thresh = CMP_W'(1);
        else               thresh = CMP_W'(4) << trig;
        rda_hit = fifo_en ? ({1'b0, rx_level} >= thresh) : (rx_level != '0);
    end

    assign s_err   = err_any    & ier[IE_LS];
    assign s_rda   = rda_hit    & ier[IE_RDA];
    assign s_to    = rx_timeout & ier[IE_RTO];
    assign s_tx    = thr_req    & ier[IE_TX];
    assign any_src = s_err | s_rda | s_to | s_tx;

    always_comb begin
        if (s_err)               src = SRC_RXERR;
        else if (s_rda || s_to)  src = SRC_RXDATA;
        else if (s_tx)           src = SRC_TXREQ;
        else                     src = SRC_NONE;
        id_low = {(src == SRC_RXDATA) && s_to, src, ~any_src};
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 5,
    parameter int          LVL_W   = 6,
    parameter int unsigned DIV_RST = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [REG_W-1:0]  rx_data,
    output logic              rx_pop,
    output logic              tx_push,
    output logic [REG_W-1:0]  tx_data,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              rx_timeout,
    input  logic              tx_empty,
    input  logic              tx_idle,
    input  logic              fifo_err,
    input  logic              set_overrun,
    input  logic              set_parity,
    input  logic              set_framing,
    input  logic              set_brk,
    output logic [DIV_W-1:0]  divisor,
    output logic [1:0]        word_len,
    output logic              stop_two,
    output logic              parity_en,
    output logic              parity_even,
    output logic              parity_stick,
    output logic              break_ctl,
    output logic              unit_en,
    output logic              nrz_en,
    output logic              fifo_en,
    output logic [1:0]        rx_trig,
    output logic              tx_fifo_rst,
    output logic              rx_fifo_rst,
    output logic              irq
);
    localparam int WSEL_LSB = $clog2(DATA_W / 8);
    localparam int OFS_W    = ADDR_W - WSEL_LSB;
    localparam logic [IER_W-1:0] IER_MASK = ~(IER_W'(1) << IE_RSV);

    regs_t st_d, st_q;
    ofs_e  ofs;
    logic  rd, wr, dlab;
    logic [REG_W-1:0] wd, rd_byte, iir_word, lsr_word;
    logic [3:0] err_sticky;
    logic [3:0] id_low;
    src_e  cur_src;
    logic  any_src;
    logic  unused_bits;

    assign ofs  = ofs_e'(bus_addr[ADDR_W-1 -: OFS_W]);
    assign rd   = bus_sel & ~bus_wr;
    assign wr   = bus_sel &  bus_wr;
    assign wd   = bus_wdata[REG_W-1:0];
    assign dlab = st_q.lcr[LC_DLAB];
    assign unused_bits = ^{bus_wdata[DATA_W-1:REG_W], bus_addr[WSEL_LSB-1:0]};

    uart_rb_lsr u_lsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (rd && ofs == OFS_LSR),
        .set_oe (set_overrun),
        .set_pe (set_parity),
        .set_fe (set_framing),
        .set_bi (set_brk),
        .sticky (err_sticky)
    );

    uart_rb_intid #(.LVL_W(LVL_W)) u_intid (
        .ier        (st_q.ier),
        .fifo_en    (st_q.fifo_en),
        .trig       (st_q.trig),
        .rx_level   (rx_level),
        .rx_timeout (rx_timeout),
        .err_any    (|err_sticky),
        .thr_req    (st_q.thr_req),
        .id_low     (id_low),
        .src        (cur_src),
        .any_src    (any_src)
    );

    assign iir_word = {{2{st_q.fifo_en}}, 2'b00, id_low};
    assign lsr_word = {fifo_err, tx_empty & tx_idle, tx_empty, err_sticky, rx_level != '0};

    always_comb begin
        st_d               = st_q;
        st_d.rx_rst        = 1'b0;
        st_d.tx_rst        = 1'b0;
        st_d.tx_empty_prev = tx_empty;

        // clearing events for the transmit request
        if (rd && ofs == OFS_IIR && cur_src == SRC_TXREQ) st_d.thr_req = 1'b0;
        if (wr && ofs == OFS_DATA && !dlab)               st_d.thr_req = 1'b0;

        if (wr) begin
            unique case (ofs)
                OFS_DATA: if (dlab) st_d.div[REG_W-1:0] = wd;
                OFS_IER: begin
                    if (dlab) st_d.div[DIV_W-1:REG_W] = wd;
                    else      st_d.ier = wd[IER_W-1:0] & IER_MASK;
                end
                OFS_IIR: begin
                    st_d.fifo_en = wd[FC_EN];
                    st_d.rx_rst  = wd[FC_RXRST];
                    st_d.tx_rst  = wd[FC_TXRST];
                    st_d.trig    = wd[FC_TRIG +: 2];
                end
                OFS_LCR: st_d.lcr = wd;
                OFS_SCR: st_d.scr = wd;
                default: ;
            endcase
        end

        // setting events win over clearing ones
        if (tx_empty && !st_q.tx_empty_prev) st_d.thr_req = 1'b1;
        if (wr && ofs == OFS_IER && !dlab && wd[IE_TX] && !st_q.ier[IE_TX] && tx_empty)
            st_d.thr_req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q               <= '0;
            st_q.div           <= DIV_W'(DIV_RST);
            st_q.tx_empty_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_DATA: rd_byte = dlab ? st_q.div[REG_W-1:0] : rx_data;
            OFS_IER:  rd_byte = dlab ? st_q.div[DIV_W-1:REG_W] : {1'b0, st_q.ier};
            OFS_IIR:  rd_byte = iir_word;
            OFS_LCR:  rd_byte = st_q.lcr;
            OFS_LSR:  rd_byte = lsr_word;
            OFS_SCR:  rd_byte = st_q.scr;
            default:  rd_byte = '0;
        endcase
    end

    assign bus_rdata    = {{(DATA_W-REG_W){1'b0}}, rd_byte};
    assign rx_pop       = rd && ofs == OFS_DATA && !dlab;
    assign tx_push      = wr && ofs == OFS_DATA && !dlab;
    assign tx_data      = wd;

    assign divisor      = st_q.div;
    assign word_len     = st_q.lcr[1:0];
    assign stop_two     = st_q.lcr[LC_STOP];
    assign parity_en    = st_q.lcr[LC_PEN];
    assign parity_even  = st_q.lcr[LC_EVEN];
    assign parity_stick = st_q.lcr[LC_STICK];
    assign break_ctl    = st_q.lcr[LC_BRK];
    assign unit_en      = st_q.ier[IE_UNIT];
    assign nrz_en       = st_q.ier[IE_NRZ];
    assign fifo_en      = st_q.fifo_en;
    assign rx_trig      = st_q.trig;
    assign tx_fifo_rst  = st_q.tx_rst;
    assign rx_fifo_rst  = st_q.rx_rst;
    assign irq          = st_q.ier[IE_UNIT] & any_src;
endmodule

// File: rtl/uart_rb_chk.sv
module uart_rb_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_pop,
    input logic              tx_push,
    input logic              dlab,
    input logic              unit_en,
    input logic              irq,
    input logic              tx_fifo_rst,
    input logic              rx_fifo_rst,
    input logic [3:0]        sticky,
    input logic              any_set
);
    logic [2:0] word;
    logic fcr_wr, lsr_rd, iir_rd;
    assign word   = bus_addr[ADDR_W-1 -: 3];
    assign fcr_wr = bus_sel && bus_wr && word == 3'd2;
    assign lsr_rd = bus_sel && !bus_wr && word == 3'd5;
    assign iir_rd = bus_sel && !bus_wr && word == 3'd2;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:8] == '0);                                      // R2
    AST_DIV_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dlab |-> (!rx_pop && !tx_push));                                   // R3
    AST_TXRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && bus_wdata[2]) |=> tx_fifo_rst);                         // R8
    AST_RXRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && bus_wdata[1]) |=> rx_fifo_rst);                         // R8
    AST_RST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        !fcr_wr |=> (!tx_fifo_rst && !rx_fifo_rst));                       // R8
    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !any_set) |=> sticky == 4'b0000);                       // R10
    AST_IIR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && unit_en) |-> (bus_rdata[0] == !irq));                   // R12
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |-> !irq);                                                // R14
endmodule

bind uart_regbank uart_rb_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .rx_pop      (rx_pop),
    .tx_push     (tx_push),
    .dlab        (dlab),
    .unit_en     (unit_en),
    .irq         (irq),
    .tx_fifo_rst (tx_fifo_rst),
    .rx_fifo_rst (rx_fifo_rst),
    .sticky      (err_sticky),
    .any_set     (set_overrun | set_parity | set_framing | set_brk)
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_data = '0;
    logic        rx_pop, tx_push;
    logic [7:0]  tx_data;
    logic [5:0]  rx_level = '0;
    logic        rx_timeout = 1'b0, tx_empty = 1'b0, tx_idle = 1'b0, fifo_err = 1'b0;
    logic        set_overrun = 1'b0, set_parity = 1'b0, set_framing = 1'b0, set_brk = 1'b0;
    logic [15:0] divisor;
    logic [1:0]  word_len, rx_trig;
    logic        stop_two, parity_en, parity_even, parity_stick, break_ctl;
    logic        unit_en, nrz_en, fifo_en, tx_fifo_rst, rx_fifo_rst, irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] rv;
    logic last_pop, last_push, last_txr, last_rxr;
    logic [7:0] last_txd;

    always #4 clk = ~clk;

    uart_regbank u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1 last_push = tx_push; last_txd = tx_data;
        @(posedge clk);
        #1 last_txr = tx_fifo_rst; last_rxr = rx_fifo_rst;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata; last_pop = rx_pop;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    function automatic int thr_of(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (4 << c);
    endfunction

    function automatic logic [8:0] model_iir(input logic fen, input logic [1:0] trig,
        input logic [6:0] ier, input int lvl, input logic to, input logic err, input logic txr);
        logic rda, tos, errs, txs;
        logic [7:0] b;
        rda  = (fen ? (lvl >= thr_of(trig)) : (lvl != 0)) & ier[0];
        tos  = to & ier[4];
        errs = err & ier[2];
        txs  = txr & ier[1];
        b    = fen ? 8'hC0 : 8'h00;
        if (errs)            b = b | 8'h06;
        else if (rda || tos) b = b | 8'h04 | (tos ? 8'h08 : 8'h00);
        else if (txs)        b = b | 8'h02;
        else                 b = b | 8'h01;
        return {ier[6] & (errs | rda | tos | txs), b};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [8:0] e;
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_reg(5'h04, rv); chk("R1 ier", rv, 32'h0);
        rd_reg(5'h0C, rv); chk("R1 lcr", rv, 32'h0);
        rd_reg(5'h1C, rv); chk("R1 scr", rv, 32'h0);
        rd_reg(5'h08, rv); chk("R1 iir", rv, 32'h01);
        chk("R1 outputs", {divisor, 13'd0, irq, tx_fifo_rst, rx_fifo_rst}, {16'd1, 16'd0});

        // R2 upper bits and gaps
        rd_reg(5'h10, rv); chk("R2 gap 0x10", rv, 32'h0);
        rd_reg(5'h18, rv); chk("R2 gap 0x18", rv, 32'h0);
        wr_reg(5'h1C, 32'hFFFF_FFA5);
        rd_reg(5'h1C, rv); chk("R2 upper zero", rv, 32'hA5);

        // R3 divisor access
        wr_reg(5'h0C, 32'h80);
        wr_reg(5'h00, 32'h34); chk("R3 no push", last_push, 1'b0);
        wr_reg(5'h04, 32'h12);
        chk("R3 divisor", divisor, 16'h1234);
        rd_reg(5'h00, rv); chk("R3 low byte", rv, 32'h34); chk("R3 no pop", last_pop, 1'b0);
        rd_reg(5'h04, rv); chk("R3 high byte", rv, 32'h12);
        wr_reg(5'h0C, 32'h03);
        rd_reg(5'h04, rv); chk("R3 ier back", rv, 32'h0);

        // R4 data slot
        rx_data = 8'h5A;
        rd_reg(5'h00, rv); chk("R4 rx data", rv, 32'h5A); chk("R4 pop", last_pop, 1'b1);
        wr_reg(5'h00, 32'h77);
        chk("R4 push", {last_push, last_txd}, {1'b1, 8'h77});

        // R5 interrupt enable
        wr_reg(5'h04, 32'h7F);
        rd_reg(5'h04, rv); chk("R5 ier reserved", rv, 32'h77);
        chk("R5 unit/nrz", {unit_en, nrz_en}, 2'b11);
        wr_reg(5'h04, 32'h00);
        chk("R5 unit/nrz off", {unit_en, nrz_en}, 2'b00);

        // R6 line control and scratch
        wr_reg(5'h0C, 32'h7B);
        chk("R6 fields", {break_ctl, parity_stick, parity_even, parity_en, stop_two, word_len}, 7'b1111011);
        wr_reg(5'h1C, 32'h3C);
        rd_reg(5'h1C, rv); chk("R6 scratch", rv, 32'h3C);
        rd_reg(5'h0C, rv); chk("R6 lcr unchanged", rv, 32'h7B);
        wr_reg(5'h0C, 32'h03);

        // R7 R8 FIFO control
        wr_reg(5'h08, 32'hC7);
        chk("R8 pulses", {last_txr, last_rxr}, 2'b11);
        @(posedge clk); #1 chk("R8 single cycle", {tx_fifo_rst, rx_fifo_rst}, 2'b00);
        chk("R7 fifo_en trig", {fifo_en, rx_trig}, 3'b111);
        rd_reg(5'h08, rv); chk("R7 iir fifo bits", rv, 32'hC1);
        wr_reg(5'h08, 32'h02);
        chk("R8 rx only", {last_txr, last_rxr}, 2'b01);

        // R11 directed thresholds
        wr_reg(5'h04, 32'h41);
        wr_reg(5'h08, 32'h41);
        rx_level = 6'd7;
        rd_reg(5'h08, rv); chk("R11 below 8", rv, 32'hC1);
        rx_level = 6'd8;
        rd_reg(5'h08, rv); chk("R11 at 8", rv, 32'hC4);
        chk("R14 irq rda", irq, 1'b1);

        // R11 R12 R14 random mix
        for (int i = 0; i < 300; i++) begin
            logic [6:0] ier_v;
            logic [1:0] trig_v;
            logic fen_v;
            ier_v  = {$urandom_range(0,1) == 1, $urandom_range(0,1) == 1,
                      $urandom_range(0,1) == 1, 1'b0, $urandom_range(0,1) == 1,
                      1'b0, $urandom_range(0,1) == 1};
            trig_v = 2'($urandom_range(0,3));
            fen_v  = $urandom_range(0,1) == 1;
            wr_reg(5'h04, {25'd0, ier_v});
            wr_reg(5'h08, {24'd0, trig_v, 5'd0, fen_v});
            rx_level   = 6'($urandom_range(0,40));
            rx_timeout = $urandom_range(0,3) == 0;
            e = model_iir(fen_v, trig_v, ier_v, int'(rx_level), rx_timeout, 1'b0, 1'b0);
            rd_reg(5'h08, rv); chk("R12 R11 random iir", rv, {24'd0, e[7:0]});
            chk("R14 random irq", irq, e[8]);
        end
        rx_timeout = 1'b0;
        wr_reg(5'h08, 32'h00);

        // R9 line status
        rx_level = 6'd3; fifo_err = 1'b1; tx_empty = 1'b1; tx_idle = 1'b0;
        rd_reg(5'h14, rv); chk("R9 lsr", rv, 32'hA1);
        tx_idle = 1'b1;
        rd_reg(5'h14, rv); chk("R9 lsr temt", rv, 32'hE1);

        // R10 R12 errors
        rx_level = 6'd1;
        wr_reg(5'h04, 32'h05);
        @(negedge clk); set_overrun = 1'b1;
        @(negedge clk); set_overrun = 1'b0;
        rd_reg(5'h08, rv); chk("R12 error first", rv, 32'h06);
        rd_reg(5'h14, rv); chk("R10 overrun set", rv, 32'hE3);
        rd_reg(5'h14, rv); chk("R10 overrun cleared", rv, 32'hE1);
        rd_reg(5'h08, rv); chk("R12 rda after clear", rv, 32'h04);
        @(negedge clk);
        set_parity = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h14;
        #1 rv = bus_rdata;
        @(posedge clk); #1 set_parity = 1'b0; bus_sel = 1'b0;
        chk("R10 same-cycle read", rv, 32'hE1);
        rd_reg(5'h14, rv); chk("R10 strobe kept", rv, 32'hE5);
        rd_reg(5'h14, rv); chk("R10 cleared again", rv, 32'hE1);

        // R13 R14 transmit request
        rx_level = 6'd0; fifo_err = 1'b0;
        @(negedge clk); tx_empty = 1'b0;
        @(negedge clk); tx_empty = 1'b1;
        @(negedge clk);
        wr_reg(5'h04, 32'h42);
        chk("R14 irq tx", irq, 1'b1);
        rd_reg(5'h08, rv); chk("R13 edge request", rv, 32'h02);
        rd_reg(5'h08, rv); chk("R13 read clears", rv, 32'h01);
        chk("R14 irq low", irq, 1'b0);
        @(negedge clk); tx_empty = 1'b0;
        @(negedge clk); tx_empty = 1'b1;
        @(negedge clk); chk("R13 edge again irq", irq, 1'b1);
        wr_reg(5'h00, 32'h11);
        chk("R13 data write clears", irq, 1'b0);
        rd_reg(5'h08, rv); chk("R13 none after write", rv, 32'h01);
        wr_reg(5'h04, 32'h40);
        wr_reg(5'h04, 32'h42);
        chk("R13 enable sets", irq, 1'b1);
        wr_reg(5'h04, 32'h02);
        chk("R14 unit gate", irq, 1'b0);
        rd_reg(5'h08, rv); chk("R13 pending without unit", rv, 32'h02);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule